// File: doc/BRIEF.md
# PAM-4 Slicer Error-Energy and Amplitude Histogram Monitor

This block watches the soft decisions entering the final slicer of a four-level (PAM-4) receiver without touching the data path. For each accepted sample it chooses the closest of the four ideal amplitudes and forms the signed distance to it. The squares of these distances are summed over a window of 2^N samples. The sum is shifted right by N to give a mean-square error that software turns into an SNR figure.

During the same window, every accepted sample also increments one of 64 amplitude bins. The result is a live picture of how the samples spread around the four levels. Each bin covers four adjacent sample codes, which sets the amplitude resolution.

Software pulses `start` with a window exponent and waits for `done`. It then reads the mean-square error and walks the bins through a read address. Results stay frozen until the next `start` or `clear`.

Top module: `pam4_slicer_monitor`

## Requirements
- R1: After reset, `busy` and `done` are 0, `mse_out` is 0 and every bin reads 0.
- R2: Samples are 8-bit two's complement. The chosen level is +96 for samples of 64 and above, +32 for 0..63, -32 for -64..-1 and -96 below -64. The per-sample error is the sample minus that level, and a one-sample window (N=0) reports its square on `mse_out`.
- R3: At the end of a window, `mse_out` equals the sum of the squared errors of its 2^N samples shifted right by N.
- R4: Each accepted sample adds one to the bin whose index is the sample's upper six bits with the sign bit inverted (offset binary, so -128..-125 is bin 0 and 124..127 is bin 63). `rd_count` shows the bin selected by `rd_bin` in the same cycle.
- R5: A bin that has reached full scale (all ones, 24 bits by default) stays at full scale when further samples land in it.
- R6: Only cycles with `smp_valid` high count toward the window. `done` rises on the clock edge that accepts the 2^N-th valid sample, and `busy` falls on that same edge. Exponents above the maximum are clamped to the maximum.
- R7: While the monitor is idle or done, samples are ignored: `mse_out`, `done` and every bin keep their values.
- R8: `start` zeroes the sum, the bins and the sample count and begins a new window, including while a window is running. `clear` returns to idle with everything zeroed.
- R9: When `start` and `clear` are high in the same cycle, `clear` wins and the monitor ends idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Slicer sample present this cycle |
| smp_data | input | 8 | Signed slicer input sample |
| start | input | 1 | Clear results and open a new window |
| clear | input | 1 | Clear results and return to idle |
| win_log2 | input | 5 | Window exponent N, captured at start |
| rd_bin | input | 6 | Histogram bin read address |
| busy | output | 1 | Window in progress |
| done | output | 1 | Window complete, results frozen |
| mse_out | output | 32 | Accumulated squared error shifted right by N |
| rd_count | output | 24 | Hit count of the addressed bin |

## Verification
The hardest condition to reach is bin saturation, because a 24-bit count needs about sixteen million hits. The bench therefore instantiates the monitor with 6-bit bin counters and pours 128 identical samples into one bin, so both the climb to full scale and the hold at full scale are covered. The slicer thresholds are swept over all 256 sample codes using one-sample windows, so each decision boundary and its neighbour are seen on `mse_out`. The remaining cases use multi-sample windows with invalid cycles mixed in, traffic after `done`, a restart in the middle of a window, and `start` and `clear` colliding.

// File: rtl/slicer_mon_pkg.sv
package slicer_mon_pkg;

    localparam int SMP_W   = 8;
    localparam int ERR_W   = SMP_W + 1;
    localparam int MAG_W   = SMP_W - 2;
    localparam int SQ_W    = 2 * MAG_W;
    localparam int BIN_W   = 6;
    localparam int NBINS   = 1 << BIN_W;

    localparam logic signed [SMP_W-1:0] LVL_OUTER = 8'sd96;
    localparam logic signed [SMP_W-1:0] LVL_INNER = 8'sd32;
    localparam logic signed [SMP_W-1:0] THR_OUTER = 8'sd64;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mon_state_t;

    typedef struct packed {
        logic signed [ERR_W-1:0] err;
        logic [SQ_W-1:0]         sq;
        logic [BIN_W-1:0]        bin;
    } slice_res_t;

    function automatic logic signed [SMP_W-1:0] nearest_level(
        input logic signed [SMP_W-1:0] x);
        if (x >= THR_OUTER)       return LVL_OUTER;
        else if (x >= 0)          return LVL_INNER;
        else if (x >= -THR_OUTER) return -LVL_INNER;
        else                      return -LVL_OUTER;
    endfunction

    function automatic logic [BIN_W-1:0] amp_bin(
        input logic [SMP_W-1:0] x);
        return {~x[SMP_W-1], x[SMP_W-2:SMP_W-BIN_W]};
    endfunction

endpackage

// File: rtl/pam4_level_slicer.sv
module pam4_level_slicer
    import slicer_mon_pkg::*;
(
    input  logic signed [SMP_W-1:0] smp,
    output slice_res_t              res
);

    logic signed [SMP_W-1:0] lvl;
    logic signed [ERR_W-1:0] err;
    logic [ERR_W-1:0]        abs_err;
    logic [MAG_W-1:0]        mag;

    always_comb begin
        lvl     = nearest_level(smp);
        err     = ERR_W'(smp) - ERR_W'(lvl);
        abs_err = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
        mag     = abs_err[MAG_W-1:0];
        res.err = err;
        res.sq  = SQ_W'({{MAG_W{1'b0}}, mag} * {{MAG_W{1'b0}}, mag});
        res.bin = amp_bin(smp);
    end

    // Error magnitude never exceeds half the level spacing
    always_comb begin
        AST_ERR_RANGE: assert (err >= -9'sd32 && err <= 9'sd31 && abs_err <= 9'd32); // R2
    end

endmodule

// File: rtl/mse_accumulator.sv
module mse_accumulator
    import slicer_mon_pkg::*;
#(
    parameter int MAX_LOG = 20,
    localparam int ACC_W  = SQ_W + MAX_LOG,
    localparam int LOGW   = $clog2(MAX_LOG + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [SQ_W-1:0]  sq,
    input  logic [LOGW-1:0]  shift_n,
    output logic [ACC_W-1:0] mse
);

    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (en)    acc <= acc + ACC_W'(sq);
    end

    assign mse = acc >> shift_n;

    AST_ACC_MONO: assert property (@(posedge clk) disable iff (rst)
        (!clr) |=> (acc >= $past(acc))); // R3

endmodule

// File: rtl/amp_hist_bank.sv
module amp_hist_bank
    import slicer_mon_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [BIN_W-1:0] bin,
    input  logic [BIN_W-1:0] rd_bin,
    output logic [CNT_W-1:0] rd_count
);

    localparam logic [CNT_W-1:0] FULL = '1;

    logic [CNT_W-1:0] cnt [NBINS];

    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        logic hit;
        assign hit = en && (bin == BIN_W'(b));

        always_ff @(posedge clk) begin
            if (rst || clr)               cnt[b] <= '0;
            else if (hit && cnt[b] != FULL) cnt[b] <= cnt[b] + 1'b1;
        end

        AST_BIN_SAT: assert property (@(posedge clk) disable iff (rst)
            (!clr && cnt[b] == FULL) |=> (cnt[b] == FULL)); // R5
        AST_BIN_STEP: assert property (@(posedge clk) disable iff (rst)
            (!clr) |=> (cnt[b] == $past(cnt[b]) || cnt[b] == $past(cnt[b]) + 1'b1)); // R4
    end

    assign rd_count = cnt[rd_bin];

endmodule

// File: rtl/pam4_slicer_monitor.sv
module pam4_slicer_monitor
    import slicer_mon_pkg::*;
#(
    parameter int MAX_LOG = 20,
    parameter int CNT_W   = 24,
    localparam int ACC_W  = SQ_W + MAX_LOG,
    localparam int LOGW   = $clog2(MAX_LOG + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic                    start,
    input  logic                    clear,
    input  logic [LOGW-1:0]         win_log2,
    input  logic [BIN_W-1:0]        rd_bin,
    output logic                    busy,
    output logic                    done,
    output logic [ACC_W-1:0]        mse_out,
    output logic [CNT_W-1:0]        rd_count
);

    mon_state_t        state;
    logic [LOGW-1:0]   win_n;
    logic [LOGW-1:0]   win_in;
    logic [MAX_LOG:0]  seen;
    logic [MAX_LOG:0]  win_last;
    logic              accept;
    logic              wipe;
    logic              last;
    slice_res_t        sres;

    assign win_in   = (win_log2 > LOGW'(MAX_LOG)) ? LOGW'(MAX_LOG) : win_log2;
    assign win_last = ((MAX_LOG+1)'(1) << win_n) - 1'b1;
    assign accept   = smp_valid && (state == ST_RUN) && !start && !clear;
    assign wipe     = start || clear;
    assign last     = accept && (seen == win_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            win_n <= '0;
            seen  <= '0;
        end else if (clear) begin
            state <= ST_IDLE;
            seen  <= '0;
        end else if (start) begin
            state <= ST_RUN;
            win_n <= win_in;
            seen  <= '0;
        end else if (accept) begin
            seen <= seen + 1'b1;
            if (last) state <= ST_DONE;
        end
    end

    assign busy = (state == ST_RUN);
    assign done = (state == ST_DONE);

    pam4_level_slicer u_slicer (
        .smp (smp_data),
        .res (sres)
    );

    mse_accumulator #(.MAX_LOG(MAX_LOG)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .clr     (wipe),
        .en      (accept),
        .sq      (sres.sq),
        .shift_n (win_n),
        .mse     (mse_out)
    );

    amp_hist_bank #(.CNT_W(CNT_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .clr      (wipe),
        .en       (accept),
        .bin      (sres.bin),
        .rd_bin   (rd_bin),
        .rd_count (rd_count)
    );

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start && !clear) |=> (done && $stable(mse_out))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE && $stable(mse_out))); // R7
    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (seen <= win_last)); // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clear |=> (state == ST_IDLE && mse_out == '0)); // R9
    AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
        (start && !clear) |=> (busy && mse_out == '0)); // R8

endmodule

// File: tb/pam4_slicer_monitor_test.sv
module pam4_slicer_monitor_test;

    localparam int CW = 6;
    localparam int FULL = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic signed [7:0] smp_data = '0;
    logic        start = 1'b0;
    logic        clear = 1'b0;
    logic [4:0]  win_log2 = '0;
    logic [5:0]  rd_bin = '0;
    logic        busy, done;
    logic [31:0] mse_out;
    logic [CW-1:0] rd_count;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pam4_slicer_monitor #(.MAX_LOG(20), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .start(start), .clear(clear), .win_log2(win_log2), .rd_bin(rd_bin),
        .busy(busy), .done(done), .mse_out(mse_out), .rd_count(rd_count)
    );

    function automatic int exp_sq(input int x);
        int lvl;
        int e;
        if (x >= 64)       lvl = 96;
        else if (x >= 0)   lvl = 32;
        else if (x >= -64) lvl = -32;
        else               lvl = -96;
        e = x - lvl;
        return e * e;
    endfunction

    function automatic int exp_bin(input int x);
        return (x + 128) / 4;
    endfunction

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bin_read(input int b, output int v);
        rd_bin = 6'(b);
        #1;
        v = int'(rd_count);
    endtask

    task automatic do_start(input int n);
        @(negedge clk);
        start = 1'b1;
        win_log2 = 5'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic feed(input int x, input logic v);
        smp_valid = v;
        smp_data = 8'(x);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int nz;
        int sum;
        int held;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 busy", busy == 1'b0, busy, 0);
        check("R1 done", done == 1'b0, done, 0);
        check("R1 mse", mse_out == 0, mse_out, 0);
        nz = 0;
        for (int b = 0; b < 64; b++) begin
            bin_read(b, v);
            if (v != 0) nz++;
        end
        check("R1 bins zero", nz == 0, nz, 0);

        // R2 / R4: sweep every sample code through a one-sample window
        for (int x = -128; x < 128; x++) begin
            do_start(0);
            feed(x, 1'b1);
            check("R2 done", done == 1'b1, done, 1);
            check("R2 mse", mse_out == 32'(exp_sq(x)), mse_out, exp_sq(x));
            bin_read(exp_bin(x), v);
            check("R4 bin hit", v == 1, v, 1);
        end

        // R6 / R3: 16-sample window with invalid cycles mixed in
        do_start(4);
        sum = 0;
        for (int i = 0; i < 16; i++) begin
            feed(i * 11 - 80, 1'b1);
            sum += exp_sq(i * 11 - 80);
            feed(-128, 1'b0);
            if (i == 14) begin
                check("R6 not done at 15", done == 1'b0, done, 0);
                check("R6 busy at 15", busy == 1'b1, busy, 1);
            end
        end
        check("R6 done at 16", done == 1'b1, done, 1);
        check("R6 busy low", busy == 1'b0, busy, 0);
        check("R3 mse window", mse_out == 32'(sum >> 4), mse_out, sum >> 4);
        bin_read(0, v);
        check("R6 invalid ignored", v == 0, v, 0);
        bin_read(exp_bin(30), v);
        check("R4 bin of 30", v == 1, v, 1);

        // R7: samples after done are ignored
        held = int'(mse_out);
        for (int i = 0; i < 5; i++) feed(100, 1'b1);
        check("R7 done held", done == 1'b1, done, 1);
        check("R7 mse frozen", mse_out == 32'(held), mse_out, held);
        bin_read(exp_bin(100), v);
        check("R7 bin frozen", v == 0, v, 0);

        // R5: saturate one bin
        do_start(7);
        for (int i = 0; i < 128; i++) feed(50, 1'b1);
        check("R5 done", done == 1'b1, done, 1);
        bin_read(exp_bin(50), v);
        check("R5 saturated", v == FULL, v, FULL);
        bin_read(exp_bin(50) + 1, v);
        check("R5 neighbour", v == 0, v, 0);
        check("R3 mse const", mse_out == 32'(exp_sq(50)), mse_out, exp_sq(50));

        // R6: exponent above maximum is clamped
        do_start(31);
        for (int i = 0; i < 4; i++) feed(10, 1'b1);
        check("R6 clamp busy", busy == 1'b1, busy, 1);

        // R8: restart in the middle of a window
        do_start(3);
        for (int i = 0; i < 3; i++) feed(-100, 1'b1);
        do_start(1);
        feed(10, 1'b1);
        feed(10, 1'b1);
        check("R8 restart done", done == 1'b1, done, 1);
        check("R8 restart mse", mse_out == 32'(exp_sq(10)), mse_out, exp_sq(10));
        bin_read(exp_bin(-100), v);
        check("R8 old bin wiped", v == 0, v, 0);

        // R8: clear returns to idle
        do_clear();
        check("R8 clear done", done == 1'b0, done, 0);
        check("R8 clear busy", busy == 1'b0, busy, 0);
        check("R8 clear mse", mse_out == 0, mse_out, 0);
        bin_read(exp_bin(10), v);
        check("R8 clear bin", v == 0, v, 0);
        feed(10, 1'b1);
        bin_read(exp_bin(10), v);
        check("R7 idle ignored", v == 0, v, 0);

        // R9: start and clear together
        @(negedge clk);
        start = 1'b1;
        clear = 1'b1;
        win_log2 = 5'd0;
        @(negedge clk);
        start = 1'b0;
        clear = 1'b0;
        check("R9 idle", busy == 1'b0 && done == 1'b0, busy, 0);
        feed(-20, 1'b1);
        bin_read(exp_bin(-20), v);
        check("R9 sample ignored", v == 0, v, 0);
        check("R9 mse zero", mse_out == 0, mse_out, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule